// File: doc/BRIEF.md
# Codec serial control writer

This block is a write-only serial master for two audio converter chips that share one clock line and one data line. Each chip has its own active-low select. Every transfer is a 16-bit frame, sent most significant bit first. The upper byte is a fixed 2-bit device code of `10`, then a write flag of `1`, then a 5-bit register address. The lower byte is the data. While idle, the clock, the data line and both selects sit high.

The block keeps a mirror of the 32 byte-wide registers of each chip. Because of this, it can change a masked field without reading the chip. Three command kinds are accepted through a valid/ready handshake:

- A plain write sends a byte to one chip and records it in the mirror.
- A rate update turns a sample rate in Hz into the sampling-speed field (mask `0x0F`) of register 2.
- A mute command sets or clears bit 7 of register 3.

Both masked kinds update chip 0 first and then chip 1, one frame each. Each new value is built from the mirrored byte. The duration of each phase of the serial clock is a parameter, counted in system clock cycles.

Top module: `codec_ctl_writer`

## Requirements
- R1: After reset, `serClk`, `serData` and both `serCsN` bits are high, and `cmdReady` is 1.
- R2: A plain write (`cmdKind` 0) produces one 16-bit frame on the chip given by `cmdChip`. The frame is `{2'b10, 1'b1, cmdAddr, cmdData}`, sent MSB first. Only that chip's select goes low, and the two selects are never low together.
- R3: Bit order on the line: a select falls only while the clock is high. For each bit, the clock falls, then the data line changes while the clock is low, then the clock rises, and the chip samples data on that rising edge. The data line never changes while the clock is high and a select is low.
- R4: The select rises while the clock is high, after exactly 16 rising clock edges.
- R5: Whenever `cmdReady` is 1, the clock, the data line and both selects are high.
- R6: A rate update (`cmdKind` 1) builds a speed value from `cmdRate`: `0x0A` when the rate is above 108000, `0x05` when it is above 54000 and at most 108000, and `0x00` otherwise. It writes register 2 of each chip as (mirror AND NOT `0x0F`) OR speed.
- R7: A masked update sends two frames, chip 0 first and then chip 1, and writes each result back into that chip's mirror.
- R8: A rate update with `cmdRate` equal to 0 is accepted but sends no frame and changes no mirror entry.
- R9: A mute command (`cmdKind` 2 or 3) writes register 3 of each chip with bit 7 set to `cmdMute`, keeping the other mirrored bits.
- R10: A plain write also updates the mirror, so a later masked update keeps the bits it wrote outside the mask.
- R11: `cmdReady` drops in the cycle after a command that produces frames is accepted. It stays low until the last frame has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle and able to accept a command |
| cmdKind | input | 2 | 0 plain write, 1 rate update, 2 or 3 mute |
| cmdChip | input | 1 | Target chip for a plain write |
| cmdAddr | input | 5 | Register address for a plain write |
| cmdData | input | 8 | Data byte for a plain write |
| cmdRate | input | 18 | Sample rate in Hz for a rate update |
| cmdMute | input | 1 | 1 sets soft mute, 0 clears it |
| serClk | output | 1 | Serial clock, idles high |
| serData | output | 1 | Serial data, idles high |
| serCsN | output | 2 | Active-low chip selects, bit n for chip n |

## Verification
Plain writes to each chip, with different addresses and data patterns, show that the header, the address and the data bits all reach the right select in the right order. Rate updates are made at 96000, 108000, 108001, 54000, 192000 and 0. Placed on both sides of each threshold, they separate a strict from an inclusive comparison, and the zero rate shows the no-write case. A plain write that fills bits outside the mask on one chip comes before the masked updates. The differing results on chip 0 and chip 1 then show the read-modify-write through the mirror and the chip order. Setting and clearing mute over a preloaded register 3 shows that only bit 7 moves.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  localparam int CHIPS  = 2;
  localparam int REGS   = 32;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int FRAME_W = 2 + 1 + ADDR_W + DATA_W;
  localparam logic [1:0] DEV_CODE = 2'b10;

  localparam logic [ADDR_W-1:0] SPEED_REG = 5'd2;
  localparam logic [DATA_W-1:0] SPEED_MASK = 8'h0F;
  localparam logic [DATA_W-1:0] SPEED_FAST = 8'h0A;
  localparam logic [DATA_W-1:0] SPEED_MID  = 8'h05;
  localparam logic [ADDR_W-1:0] MUTE_REG = 5'd3;
  localparam logic [DATA_W-1:0] MUTE_BIT = 8'h80;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_PREP, S_SEL, S_BLOW, S_BDATA, S_BHIGH, S_FIN
  } ctlState_e;

  typedef struct packed {
    logic loadFrame;
    logic selChip;
    logic dropClk;
    logic shiftData;
    logic raiseClk;
    logic releaseAll;
  } strobe_t;
endpackage

// File: rtl/codec_ctl_ctrl.sv
module codec_ctl_ctrl
  import codec_ctl_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int RATE_W  = 18,
  parameter int RATE_HI = 108000,
  parameter int RATE_LO = 54000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdKind,
  input  logic              cmdChip,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [RATE_W-1:0] cmdRate,
  input  logic              cmdMute,
  output strobe_t           strb,
  output logic              opChip,
  output logic              opMasked,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opMask,
  output logic [DATA_W-1:0] opValue
);
  localparam int TW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(HALF_CYCLES - 1);

  ctlState_e state, nxt;
  logic [TW-1:0] timer;
  logic [3:0]    bitIdx;
  logic          timerLast, isRate, isMute, dropCmd, accept;

  assign timerLast = (timer == T_LAST);
  assign isMute    = cmdKind[1];
  assign isRate    = !cmdKind[1] && cmdKind[0];
  assign dropCmd   = isRate && (cmdRate == '0);
  assign cmdReady  = (state == S_IDLE);
  assign accept    = cmdValid && cmdReady;

  always_comb begin
    strb = '0;
    nxt  = state;
    unique case (state)
      S_IDLE:  if (accept && !dropCmd) nxt = S_LOAD;
      S_LOAD:  begin strb.loadFrame = 1'b1; nxt = S_PREP; end
      S_PREP:  if (timerLast) begin strb.selChip = 1'b1; nxt = S_SEL; end
      S_SEL:   if (timerLast) begin strb.dropClk = 1'b1; nxt = S_BLOW; end
      S_BLOW:  if (timerLast) begin strb.shiftData = 1'b1; nxt = S_BDATA; end
      S_BDATA: if (timerLast) begin strb.raiseClk = 1'b1; nxt = S_BHIGH; end
      S_BHIGH: if (timerLast) begin
        if (bitIdx == 4'd15) begin strb.releaseAll = 1'b1; nxt = S_FIN; end
        else begin strb.dropClk = 1'b1; nxt = S_BLOW; end
      end
      S_FIN:   if (timerLast) nxt = (opMasked && !opChip) ? S_LOAD : S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      timer    <= '0;
      bitIdx   <= '0;
      opChip   <= 1'b0;
      opMasked <= 1'b0;
      opAddr   <= '0;
      opMask   <= '0;
      opValue  <= '0;
    end else begin
      state <= nxt;
      timer <= (state != nxt || state == S_IDLE) ? '0 : timer + 1'b1;
      if (state == S_LOAD) bitIdx <= '0;
      else if (state == S_BHIGH && nxt == S_BLOW) bitIdx <= bitIdx + 1'b1;
      if (state == S_FIN && nxt == S_LOAD) opChip <= 1'b1;
      if (accept && !dropCmd) begin
        opMasked <= cmdKind != 2'd0;
        opChip   <= (cmdKind == 2'd0) ? cmdChip : 1'b0;
        if (isMute) begin
          opAddr  <= MUTE_REG;
          opMask  <= MUTE_BIT;
          opValue <= cmdMute ? MUTE_BIT : '0;
        end else if (isRate) begin
          opAddr  <= SPEED_REG;
          opMask  <= SPEED_MASK;
          opValue <= (cmdRate > RATE_W'(RATE_HI)) ? SPEED_FAST :
                     (cmdRate > RATE_W'(RATE_LO)) ? SPEED_MID : '0;
        end else begin
          opAddr  <= cmdAddr;
          opMask  <= '1;
          opValue <= cmdData;
        end
      end
    end
  end

  // R7: second frame of a masked update always targets chip 1
  p_chip_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FIN && nxt == S_LOAD) |=> (opChip && opMasked));
endmodule

// File: rtl/codec_ctl_dp.sv
module codec_ctl_dp
  import codec_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              opChip,
  input  logic              opMasked,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opMask,
  input  logic [DATA_W-1:0] opValue,
  output logic              serClk,
  output logic              serData,
  output logic [CHIPS-1:0]  serCsN
);
  logic [DATA_W-1:0]  mirror [CHIPS][REGS];
  logic [FRAME_W-1:0] shiftReg;
  logic               curChip;
  logic [DATA_W-1:0]  oldVal, newVal;

  assign oldVal = mirror[opChip][opAddr];
  assign newVal = opMasked ? ((oldVal & ~opMask) | opValue) : opValue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CHIPS; c++)
        for (int r = 0; r < REGS; r++)
          mirror[c][r] <= '0;
      shiftReg <= '0;
      curChip  <= 1'b0;
      serClk   <= 1'b1;
      serData  <= 1'b1;
      serCsN   <= '1;
    end else begin
      if (strb.loadFrame) begin
        mirror[opChip][opAddr] <= newVal;
        shiftReg <= {DEV_CODE, 1'b1, opAddr, newVal};
        curChip  <= opChip;
      end
      if (strb.selChip) serCsN[curChip] <= 1'b0;
      if (strb.dropClk) serClk <= 1'b0;
      if (strb.shiftData) begin
        serData  <= shiftReg[FRAME_W-1];
        shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      end
      if (strb.raiseClk) serClk <= 1'b1;
      if (strb.releaseAll) begin
        serClk  <= 1'b1;
        serData <= 1'b1;
        serCsN  <= '1;
      end
    end
  end

  p_one_select_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(serCsN) >= CHIPS - 1);
  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk) && !(&serCsN) && !(&$past(serCsN))) |-> $stable(serData));
  p_release_clk_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(&serCsN) |-> serClk);
endmodule

// File: rtl/codec_ctl_writer.sv
module codec_ctl_writer
  import codec_ctl_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int RATE_W  = 18,
  parameter int RATE_HI = 108000,
  parameter int RATE_LO = 54000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdKind,
  input  logic              cmdChip,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [RATE_W-1:0] cmdRate,
  input  logic              cmdMute,
  output logic              serClk,
  output logic              serData,
  output logic [CHIPS-1:0]  serCsN
);
  strobe_t           strb;
  logic              opChip, opMasked;
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opMask, opValue;

  codec_ctl_ctrl #(
    .HALF_CYCLES(HALF_CYCLES), .RATE_W(RATE_W), .RATE_HI(RATE_HI), .RATE_LO(RATE_LO)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdChip(cmdChip), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .cmdRate(cmdRate), .cmdMute(cmdMute), .strb(strb), .opChip(opChip),
    .opMasked(opMasked), .opAddr(opAddr), .opMask(opMask), .opValue(opValue)
  );

  codec_ctl_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opChip(opChip), .opMasked(opMasked),
    .opAddr(opAddr), .opMask(opMask), .opValue(opValue),
    .serClk(serClk), .serData(serData), .serCsN(serCsN)
  );

  p_idle_pins_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (serClk && serData && (&serCsN)));
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !(cmdKind == 2'd1 && cmdRate == '0)) |=> !cmdReady);
endmodule

// File: tb/codec_ctl_writer_tb.sv
module codec_ctl_writer_tb_top;
  localparam int HALF = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, cmdReady;
  logic [1:0] cmdKind = '0;
  logic cmdChip = 1'b0;
  logic [4:0] cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic [17:0] cmdRate = '0;
  logic cmdMute = 1'b0;
  logic serClk, serData;
  logic [1:0] serCsN;

  int checks = 0, fails = 0, cycles = 0;
  int frameCount = 0, orderErr = 0;
  logic [15:0] frameWord [64];
  int frameChip [64];
  int frameBits [64];
  logic [15:0] shiftIn = '0;
  int bitsIn = 0;
  logic prevClk = 1'b1, prevData = 1'b1;
  logic [1:0] prevCs = 2'b11;

  codec_ctl_writer #(.HALF_CYCLES(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdChip(cmdChip), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .cmdRate(cmdRate), .cmdMute(cmdMute), .serClk(serClk), .serData(serData),
    .serCsN(serCsN)
  );

  always #5 clk = ~clk;

  // line monitor, sampled away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (serClk && !prevClk && !(&serCsN) && !(&prevCs)) begin
        shiftIn = {shiftIn[14:0], serData};
        bitsIn++;
      end
      if (serClk && prevClk && !(&serCsN) && !(&prevCs) && serData != prevData)
        orderErr++;
      if ((&prevCs) && !(&serCsN) && !serClk) orderErr++;
      if (!(&prevCs) && (&serCsN)) begin
        if (!serClk) orderErr++;
        if (frameCount < 64) begin
          frameWord[frameCount] = shiftIn;
          frameChip[frameCount] = prevCs[0] ? 1 : 0;
          frameBits[frameCount] = bitsIn;
        end
        frameCount++;
        shiftIn = '0;
        bitsIn = 0;
      end
    end
    prevClk = serClk;
    prevData = serData;
    prevCs = serCsN;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] kind, input logic chip, input logic [4:0] addr,
                      input logic [7:0] data, input logic [17:0] rate, input logic mute);
    @(negedge clk);
    cmdKind = kind; cmdChip = chip; cmdAddr = addr; cmdData = data;
    cmdRate = rate; cmdMute = mute; cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (!cmdReady) @(negedge clk);
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic checkFrame(input int idx, input int chip, input logic [15:0] word, input string tag);
    check(frameChip[idx] == chip, {tag, " chip"}, frameChip[idx], chip);
    check(frameWord[idx] == word, {tag, " word"}, frameWord[idx], word);
    check(frameBits[idx] == 16, {tag, " bits R4"}, frameBits[idx], 16);
  endtask

  task automatic rateCase(input logic [17:0] rate, input logic [15:0] w0,
                          input logic [15:0] w1, input string tag);
    int base = frameCount;
    send(2'd1, 1'b0, 5'd0, 8'd0, rate, 1'b0);
    waitIdle();
    check(frameCount - base == 2, {tag, " frame count R7"}, frameCount - base, 2);
    checkFrame(base, 0, w0, {tag, " chip0 R6"});
    checkFrame(base + 1, 1, w1, {tag, " chip1 R7"});
  endtask

  task automatic testReset();
    check(serClk && serData && serCsN == 2'b11, "R1 idle pins", {serClk, serData, serCsN}, 4'hF);
    check(cmdReady == 1'b1, "R1 ready", cmdReady, 1);
  endtask

  task automatic testPlain();
    int base = frameCount;
    send(2'd0, 1'b0, 5'd2, 8'hF0, '0, 1'b0);
    @(negedge clk);
    check(cmdReady == 1'b0, "R11 busy after accept", cmdReady, 0);
    waitIdle();
    check(serClk && serData && serCsN == 2'b11, "R5 idle after frame", {serClk, serData, serCsN}, 4'hF);
    checkFrame(base, 0, 16'hA2F0, "R2 plain chip0");
    send(2'd0, 1'b1, 5'h1F, 8'h5A, '0, 1'b0);
    waitIdle();
    checkFrame(base + 1, 1, 16'hBF5A, "R2 plain chip1");
    check(frameCount - base == 2, "R2 one frame each", frameCount - base, 2);
    check(orderErr == 0, "R3 line ordering", orderErr, 0);
  endtask

  task automatic testRates();
    rateCase(18'd96000,  16'hA2F5, 16'hA205, "R10 rate 96000");
    rateCase(18'd108000, 16'hA2F5, 16'hA205, "R6 rate 108000");
    rateCase(18'd108001, 16'hA2FA, 16'hA20A, "R6 rate 108001");
    rateCase(18'd54000,  16'hA2F0, 16'hA200, "R6 rate 54000");
    rateCase(18'd192000, 16'hA2FA, 16'hA20A, "R6 rate 192000");
  endtask

  task automatic testZeroRate();
    int base = frameCount;
    send(2'd1, 1'b0, 5'd0, 8'd0, 18'd0, 1'b0);
    repeat (60 * HALF) @(negedge clk);
    check(frameCount == base, "R8 zero rate no frame", frameCount - base, 0);
    rateCase(18'd50000, 16'hA2F0, 16'hA200, "R8 mirror untouched");
  endtask

  task automatic testMute();
    int base;
    send(2'd0, 1'b1, 5'd3, 8'h13, '0, 1'b0);
    waitIdle();
    base = frameCount;
    send(2'd2, 1'b0, 5'd0, 8'd0, '0, 1'b1);
    waitIdle();
    checkFrame(base, 0, 16'hA380, "R9 mute on chip0");
    checkFrame(base + 1, 1, 16'hA393, "R9 mute on chip1");
    send(2'd3, 1'b1, 5'd0, 8'd0, '0, 1'b0);
    waitIdle();
    checkFrame(base + 2, 0, 16'hA300, "R9 mute off chip0");
    checkFrame(base + 3, 1, 16'hA313, "R9 mute off chip1");
    check(orderErr == 0, "R3 R4 ordering overall", orderErr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlain();
    testRates();
    testZeroRate();
    testMute();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule